// File: doc/BRIEF.md
# Shared-Pin Test Access Port Mode Controller

This block lets the test-clock, test-data-in and test-data-out pads of a chip serve as ordinary user I/O until test access is wanted. It contains a standard sixteen-state test access port (TAP) controller clocked by the test clock. It also holds a flag that records whether the three pads currently belong to the test logic or to the user I/O path. For each pad it produces a select and an output enable, and for the data-out pad it also produces the driven value.

A strap input fixes the pins as test-only. When the strap is low, the pins are shared. In shared operation, a low level on the mode-select line moves the pads over to test use. They stay there until the TAP next arrives in its reset state, and at that point they return to user control. A one-bit bypass register and a one-bit instruction placeholder give the shift states a real serial path, so the data-out pad can be exercised.

Top module: `shared_tap_ctrl`

## Requirements
- R1: The TAP advances on every rising test-clock edge through the standard sixteen states, following the mode-select line. `tap_state_o` uses this encoding: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R2: From any state, five consecutive rising edges with the mode-select line high leave the TAP in state 0.
- R3: While `rst_ni` is low, the TAP is in state 0 and the shared-pin flag is clear. With `dedicated_i` low, all three pads are then under user control.
- R4: With `dedicated_i` low, a mode-select low seen at rising edge k sets the flag at edge k+2, so that `pad_sel_o` reads 3'b111 from then on. The flag stays set until the TAP re-enters state 0.
- R5: On the rising edge at which the TAP enters state 0 from another state, the flag clears in that same edge. `pad_sel_o` returns to 3'b000 when `dedicated_i` is low.
- R6: With `dedicated_i` high, `pad_sel_o` is 3'b111 in every state, state 0 included.
- R7: Pad index 0 is the test clock, 1 is test-data-in and 2 is test-data-out. In test use, pads 0 and 1 have enable 0 and data 0. In user use, every pad passes `user_oe_i` and `user_dout_i` through unchanged.
- R8: In test use, the enable of pad 2 is high only while the TAP is in shift-DR or shift-IR. Its enable and data are updated on the falling test-clock edge.
- R9: The bypass bit loads 0 in capture-DR and takes test-data-in on each rising edge in shift-DR. During shift-DR, pad 2 shows the bypass bit, so the first bit shifted out is 0 and each later bit is the test-data-in bit from one clock earlier.
- R10: The instruction placeholder bit loads 1 in capture-IR and takes test-data-in in shift-IR. During shift-IR, pad 2 shows that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| dedicated_i | input | 1 | Strap: 1 keeps pins permanently in test use |
| tms_i | input | 1 | Mode-select line |
| tdi_i | input | 1 | Test data in |
| user_oe_i | input | 3 | User output enables for pads 0..2 |
| user_dout_i | input | 3 | User output data for pads 0..2 |
| pad_sel_o | output | 3 | Per-pad owner select, 1 = test logic |
| pad_oe_o | output | 3 | Per-pad output enable |
| pad_dout_o | output | 3 | Per-pad output data |
| tap_state_o | output | 4 | Current TAP state (R1 encoding) |

## Verification
Two things can fall on the same rising edge: the TAP landing in its reset state, and the shared-pin flag clearing, which releases the pads. A pending low on the mode-select line could also still be travelling through the synchroniser at that edge. The stimulus provokes this coincidence with a biased random walk that alternates short low pulses with runs of highs, so the TAP keeps entering and leaving the reset state around fresh lows. Each edge is judged against a cycle-exact model of the state, the flag and the pad controls, and a separate check fires on every reset-state entry to confirm the pads were released in that same edge.

// File: rtl/shared_tap_pkg.sv
package shared_tap_pkg;
  localparam int NUM_PINS = 3;
  localparam int PIN_TCK  = 0;
  localparam int PIN_TDI  = 1;
  localparam int PIN_TDO  = 2;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SHIFT_DR = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAUSE_DR = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SHIFT_IR = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAUSE_IR = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import shared_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o,
  output logic       reset_enter_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:    state_d = tms_i ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   state_d = tms_i ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   state_d = tms_i ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR: state_d = tms_i ? ST_EX1_DR   : ST_SHIFT_DR;
      ST_EX1_DR:   state_d = tms_i ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: state_d = tms_i ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   state_d = tms_i ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   state_d = tms_i ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   state_d = tms_i ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR: state_d = tms_i ? ST_EX1_IR   : ST_SHIFT_IR;
      ST_EX1_IR:   state_d = tms_i ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: state_d = tms_i ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   state_d = tms_i ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   state_d = tms_i ? ST_SEL_DR   : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o       = state_q;
  assign reset_enter_o = (state_d == ST_RESET) && (state_q != ST_RESET);

  // run length of sampled highs, kept for checking only
  logic [2:0] high_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                high_run_q <= 3'd0;
    else if (!tms_i)            high_run_q <= 3'd0;
    else if (high_run_q < 3'd5) high_run_q <= high_run_q + 3'd1;
  end

  a_r2_five_high: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (high_run_q == 3'd5) |-> (state_q == ST_RESET));
  a_r1_reset_hold: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_RESET && tms_i) |=> (state_q == ST_RESET));
  a_r1_leave_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_RESET && !tms_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pin_mode_tracker.sv
module pin_mode_tracker #(
  parameter int SYNC_STAGES = 2
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic reset_enter_i,
  output logic shared_test_o
);
  logic [SYNC_STAGES-1:0] low_sync_q;
  logic                   flag_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) low_sync_q <= '0;
        else         low_sync_q <= ~tms_i;
      end
    end else begin : g_chain
      always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) low_sync_q <= '0;
        else         low_sync_q <= {low_sync_q[SYNC_STAGES-2:0], ~tms_i};
      end
    end
  endgenerate

  // reset-state entry wins over a pending low
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                         flag_q <= 1'b0;
    else if (reset_enter_i)              flag_q <= 1'b0;
    else if (low_sync_q[SYNC_STAGES-1])  flag_q <= 1'b1;
  end

  assign shared_test_o = flag_q;

  a_r4_sticky: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (flag_q && !reset_enter_i) |=> flag_q);
  a_r5_clear_on_reset: assert property (@(posedge tck_i) disable iff (!rst_ni)
    reset_enter_i |=> !flag_q);
  a_r4_set_after_low: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (low_sync_q[SYNC_STAGES-1] && !reset_enter_i) |=> flag_q);
endmodule

// File: rtl/scan_path.sv
module scan_path
  import shared_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  output logic       tdo_o,
  output logic       tdo_en_o
);
  logic bypass_q, ir_bit_q, tdo_q, tdo_en_q;
  logic shifting;

  assign shifting = (state_i == ST_SHIFT_DR) || (state_i == ST_SHIFT_IR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
      ir_bit_q <= 1'b1;
    end else begin
      if (state_i == ST_CAP_DR)        bypass_q <= 1'b0;
      else if (state_i == ST_SHIFT_DR) bypass_q <= tdi_i;
      if (state_i == ST_CAP_IR)        ir_bit_q <= 1'b1;
      else if (state_i == ST_SHIFT_IR) ir_bit_q <= tdi_i;
    end
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= (state_i == ST_SHIFT_IR) ? ir_bit_q : bypass_q;
      tdo_en_q <= shifting;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;

  a_r8_en_tracks_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_q == shifting);
  a_r9_capture_zero: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR) |=> !bypass_q);
  a_r10_capture_one: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> ir_bit_q);
endmodule

// File: rtl/shared_tap_ctrl.sv
module shared_tap_ctrl
  import shared_tap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                tck_i,
  input  logic                rst_ni,
  input  logic                dedicated_i,
  input  logic                tms_i,
  input  logic                tdi_i,
  input  logic [NUM_PINS-1:0] user_oe_i,
  input  logic [NUM_PINS-1:0] user_dout_i,
  output logic [NUM_PINS-1:0] pad_sel_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_dout_o,
  output logic [3:0]          tap_state_o
);
  tap_state_e state;
  logic reset_enter, shared_test, test_use, tdo, tdo_en;

  tap_fsm u_fsm (
    .tck_i         (tck_i),
    .rst_ni        (rst_ni),
    .tms_i         (tms_i),
    .state_o       (state),
    .reset_enter_o (reset_enter)
  );

  pin_mode_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .tck_i         (tck_i),
    .rst_ni        (rst_ni),
    .tms_i         (tms_i),
    .reset_enter_i (reset_enter),
    .shared_test_o (shared_test)
  );

  scan_path u_scan (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state),
    .tdo_o    (tdo),
    .tdo_en_o (tdo_en)
  );

  assign test_use    = dedicated_i | shared_test;
  assign tap_state_o = state;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pad
    assign pad_sel_o[g] = test_use;
    if (g == PIN_TDO) begin : g_out
      assign pad_oe_o[g]   = test_use ? tdo_en : user_oe_i[g];
      assign pad_dout_o[g] = test_use ? tdo    : user_dout_i[g];
    end else begin : g_in
      assign pad_oe_o[g]   = test_use ? 1'b0 : user_oe_i[g];
      assign pad_dout_o[g] = test_use ? 1'b0 : user_dout_i[g];
    end
  end

  a_r6_dedicated: assert property (@(posedge tck_i) disable iff (!rst_ni)
    dedicated_i |-> (pad_sel_o == {NUM_PINS{1'b1}}));
  a_r8_tdo_quiet: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (test_use && state != ST_SHIFT_DR && state != ST_SHIFT_IR) |-> !pad_oe_o[PIN_TDO]);
  a_r7_inputs_undriven: assert property (@(posedge tck_i) disable iff (!rst_ni)
    pad_sel_o[PIN_TCK] |-> (!pad_oe_o[PIN_TCK] && !pad_oe_o[PIN_TDI]));
endmodule

// File: tb/shared_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module shared_tap_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ded = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [2:0] uoe = 3'b101;
  logic [2:0] udo = 3'b110;
  logic [2:0] sel, oe, dout;
  logic [3:0] st;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [3:0] m_st;
  logic m_s1, m_s2, m_flag, m_bp, m_ir, m_tdo, m_entered;

  always #2.5 clk = ~clk;

  shared_tap_ctrl dut_i (
    .tck_i(clk), .rst_ni(rst_n), .dedicated_i(ded), .tms_i(tms), .tdi_i(tdi),
    .user_oe_i(uoe), .user_dout_i(udo),
    .pad_sel_o(sel), .pad_oe_o(oe), .pad_dout_o(dout), .tap_state_o(st)
  );

  function automatic logic [3:0] nxt(input logic [3:0] s, input logic t);
    case (s)
      4'd0:  return t ? 4'd0  : 4'd1;
      4'd1:  return t ? 4'd2  : 4'd1;
      4'd2:  return t ? 4'd9  : 4'd3;
      4'd3:  return t ? 4'd5  : 4'd4;
      4'd4:  return t ? 4'd5  : 4'd4;
      4'd5:  return t ? 4'd8  : 4'd6;
      4'd6:  return t ? 4'd7  : 4'd6;
      4'd7:  return t ? 4'd8  : 4'd4;
      4'd8:  return t ? 4'd2  : 4'd1;
      4'd9:  return t ? 4'd0  : 4'd10;
      4'd10: return t ? 4'd12 : 4'd11;
      4'd11: return t ? 4'd12 : 4'd11;
      4'd12: return t ? 4'd15 : 4'd13;
      4'd13: return t ? 4'd14 : 4'd13;
      4'd14: return t ? 4'd15 : 4'd11;
      default: return t ? 4'd2 : 4'd1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset(input logic d);
    rst_n = 1'b0; ded = d; tms = 1'b1;
    m_st = 4'd0; m_s1 = 0; m_s2 = 0; m_flag = 0; m_bp = 0; m_ir = 1; m_tdo = 0;
    repeat (2) @(posedge clk);
    #3;
    // R3: state and pad ownership during and after reset
    chk(st == 4'd0, "R3 state", {4'd0, st}, 8'd0);
    chk(sel == {3{d}}, "R3 sel", {5'd0, sel}, {5'd0, {3{d}}});
    if (!d) chk(oe == uoe && dout == udo, "R3 pass-through", {2'd0, oe, dout}, {2'd0, uoe, udo});
    rst_n = 1'b1;
  endtask

  // drive at posedge+3, clock, update model, sample at posedge+3
  task automatic cyc(input logic t, input logic d);
    logic [3:0] ns;
    logic test, en;
    tms = t; tdi = d;
    @(posedge clk);
    ns = nxt(m_st, t);
    m_entered = (ns == 4'd0) && (m_st != 4'd0);
    if (m_entered) m_flag = 1'b0;
    else if (m_s2) m_flag = 1'b1;
    m_s2 = m_s1; m_s1 = ~t;
    if (m_st == 4'd3) m_bp = 1'b0; else if (m_st == 4'd4) m_bp = d;
    if (m_st == 4'd10) m_ir = 1'b1; else if (m_st == 4'd11) m_ir = d;
    m_st = ns;
    m_tdo = (ns == 4'd11) ? m_ir : m_bp;
    #3;
    test = ded | m_flag;
    en = (ns == 4'd4) || (ns == 4'd11);
    chk(st == m_st, "R1 state", {4'd0, st}, {4'd0, m_st});
    chk(sel == {3{test}}, ded ? "R6 sel" : "R4 sel", {5'd0, sel}, {5'd0, {3{test}}});
    if (m_entered && !ded) chk(sel == 3'b000, "R5 release", {5'd0, sel}, 8'd0);
    chk(oe[1:0] == (test ? 2'b00 : uoe[1:0]) && dout[1:0] == (test ? 2'b00 : udo[1:0]),
        "R7 input pads", {4'd0, oe[1:0], dout[1:0]},
        {4'd0, (test ? 2'b00 : uoe[1:0]), (test ? 2'b00 : udo[1:0])});
    chk(oe[2] == (test ? en : uoe[2]), "R8 tdo enable", {7'd0, oe[2]}, {7'd0, (test ? en : uoe[2])});
    if (!test) chk(dout[2] == udo[2], "R7 tdo user data", {7'd0, dout[2]}, {7'd0, udo[2]});
    else if (en) chk(dout[2] == m_tdo, (ns == 4'd11) ? "R10 ir bit" : "R9 bypass bit",
                     {7'd0, dout[2]}, {7'd0, m_tdo});
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);

    // R2: reach every state, then five highs
    for (int s = 0; s < 16; s++) begin
      int guard = 0;
      while (m_st != s[3:0] && guard < 400) begin
        lfsr_step();
        cyc(lfsr[0], lfsr[1]);
        guard++;
      end
      chk(m_st == s[3:0], "R2 reach", {4'd0, m_st}, s[7:0]);
      for (int k = 0; k < 5; k++) cyc(1'b1, lfsr[2]);
      chk(st == 4'd0, "R2 five highs", {4'd0, st}, 8'd0);
    end

    // R4/R5: exact set latency from reset state
    cyc(1'b0, 1'b0);
    chk(sel == 3'b000, "R4 not yet", {5'd0, sel}, 8'd0);
    cyc(1'b0, 1'b0);
    chk(sel == 3'b000, "R4 not yet", {5'd0, sel}, 8'd0);
    cyc(1'b1, 1'b0);
    chk(sel == 3'b111, "R4 set at k+2", {5'd0, sel}, 8'h7);

    // R9: bypass shift with a fixed pattern
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    for (int b = 0; b < 10; b++) cyc(1'b0, b[0] ^ b[2]);
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0);
    // R10: instruction placeholder shift
    cyc(1'b0, 1'b0); cyc(1'b1, 1'b0); cyc(1'b1, 1'b0); cyc(1'b0, 1'b0);
    for (int b = 0; b < 8; b++) cyc(1'b0, b[1]);
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0);

    // biased walk: short lows around frequent reset entries
    for (int i = 0; i < 4000; i++) begin
      lfsr_step();
      if (lfsr[7:5] == 3'd0) begin uoe = lfsr[10:8]; udo = lfsr[13:11]; end
      cyc((i % 64 < 32) ? lfsr[0] : (lfsr[0] | lfsr[3]), lfsr[1]);
    end

    // R6: dedicated strap
    do_reset(1'b1);
    for (int i = 0; i < 600; i++) begin
      lfsr_step();
      cyc(lfsr[0] | lfsr[4], lfsr[1]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule